// File: doc/BRIEF.md
# Instruction Prefix and Register-Operand Decoder

This block accepts, one byte per accepted transfer, the encoding of a single 64-bit-mode instruction drawn from a narrow subset. The subset has three members. The first is a register-to-register move, opcode 89h. The second is an effective-address load, opcode 8Dh, whose memory operand is a plain register-indirect base. The third is a register push, opcodes 50h to 57h. The decoder tracks the operand-size prefix (66h), the address-size prefix (67h) and the REX byte (40h to 4Fh). It folds the REX extension bits into the 3-bit register fields of the ModRM byte or the opcode, which gives full 4-bit register numbers.

When the final byte of an instruction is consumed, the block raises a one-cycle result strobe. The strobe carries the operation class, the operand size, the address size, the destination and source register numbers, and a flag that marks the source as a memory base. A further flag reports that a REX byte took effect. Downstream logic uses that flag to name byte registers: with REX, codes 4 to 7 are spl, bpl, sil and dil; without REX they are ah, ch, dh and bh. The strobe reports the illegal flag for the following cases: a SIB byte, a displacement, a memory form of the move, a register form of the address load, and any other opcode. The decoder keeps nothing from one instruction to the next.

Top module: `insn_reg_decoder`

## Requirements
- R1: While `rst` is high, `in_ready` and `dec_valid` are 0. From the first clock edge with `rst` low, `in_ready` is 1.
- R2: `dec_valid` is 1 for exactly the one cycle that follows the clock edge accepting the final byte of an instruction. Prefix bytes, opcode bytes that expect a ModRM byte, and cycles with `in_valid` low never raise it.
- R3: For opcode 89h with ModRM mod = 11b, `dec_op` = 1 (move). `dec_src` = {REX.R, ModRM[5:3]}, `dec_dst` = {REX.B, ModRM[2:0]} and `dec_src_mem` = 0. REX.R is REX bit 2 and REX.B is REX bit 0.
- R4: For move and address load, `dec_osize` is 2 (64-bit) when REX.W (REX bit 3) is set. Otherwise it is 0 (16-bit) when 66h was seen, and 1 (32-bit) in all other cases.
- R5: For opcode 8Dh with mod = 00b and rm not 4 or 5, `dec_op` = 2 (address load). `dec_dst` = {REX.R, ModRM[5:3]}, `dec_src` = {REX.B, ModRM[2:0]} and `dec_src_mem` = 1. `dec_addr64` is 0 if 67h was seen and 1 otherwise.
- R6: For opcodes 50h to 57h, `dec_op` = 3 (push) and `dec_src` = {REX.B, opcode[2:0]}. `dec_osize` is 2 even when 66h was seen, and `dec_src_mem` = 0.
- R7: A REX byte followed by a 66h or 67h byte is discarded. Its W, R and B bits have no effect, and `dec_rex` reports 0 unless a later REX byte arrives.
- R8: When two REX bytes arrive in a row, only the later one applies.
- R9: `dec_rex` is 1 whenever a REX byte took effect, including 40h, which sets no extension bit.
- R10: `dec_illegal` = 1 in these cases: for 8Dh, mod ≠ 00b or rm = 4 or rm = 5; for 89h, mod ≠ 11b; for any other non-prefix byte in opcode position. For an unknown opcode, `dec_op` = 0.
- R11: All prefix state clears after every strobe, including illegal ones, and on reset, including a reset in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| dec_valid | output | 1 | One-cycle result strobe |
| dec_op | output | 2 | 0 none, 1 move, 2 address load, 3 push |
| dec_osize | output | 2 | 0 16-bit, 1 32-bit, 2 64-bit |
| dec_addr64 | output | 1 | Memory base register is 64-bit |
| dec_dst | output | 4 | Destination register number |
| dec_src | output | 4 | Source register or memory base number |
| dec_src_mem | output | 1 | Source is a memory base, not a register value |
| dec_illegal | output | 1 | Encoding outside the supported subset |
| dec_rex | output | 1 | A REX byte took effect |

## Verification
On every cycle, the bound checker enforces the invariants that are visible at the ports. A strobe only follows an accepted byte. Push results are always 64-bit register reads. Address-load results always flag a memory source, moves never do, and an unknown operation is always flagged illegal. The values themselves can only be shown by the bench's scenarios: how the register numbers are merged, which size wins between REX.W and 66h, whether a REX byte is discarded or replaced, and whether nothing leaks from one instruction into the next. The bench drives complete byte sequences and compares the decoded fields against values worked out by hand.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned FIELD_W = 3;
  localparam int unsigned REG_W   = FIELD_W + 1;
  localparam int unsigned REXB_W  = 4;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [REG_W-1:0]  regn_t;

  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_MOV = 2'd1, OP_LEA = 2'd2, OP_PUSH = 2'd3} op_e;
  typedef enum logic [1:0] {OSZ_16 = 2'd0, OSZ_32 = 2'd1, OSZ_64 = 2'd2} osz_e;
  typedef enum logic [2:0] {
    BK_OPSZ, BK_ADSZ, BK_REX, BK_PUSH, BK_MOV, BK_LEA, BK_OTHER
  } bkind_e;

  typedef struct packed {
    logic opsz;
    logic adsz;
    logic rex_v;
    logic w;
    logic r;
    logic x;
    logic b;
  } pfx_t;

  typedef struct packed {
    op_e   op;
    osz_e  osz;
    logic  addr64;
    regn_t dst;
    regn_t src;
    logic  src_mem;
    logic  illegal;
    logic  rex_seen;
  } result_t;
endpackage

// File: rtl/rdec_byte_class.sv
module rdec_byte_class
  import rdec_pkg::*;
(
  input  byte_t  b,
  output bkind_e kind
);
  always_comb begin
    casez (b)
      8'h66:        kind = BK_OPSZ;
      8'h67:        kind = BK_ADSZ;
      8'b0100_????: kind = BK_REX;
      8'b0101_0???: kind = BK_PUSH;
      8'h89:        kind = BK_MOV;
      8'h8D:        kind = BK_LEA;
      default:      kind = BK_OTHER;
    endcase
  end
endmodule

// File: rtl/rdec_prefix_reg.sv
module rdec_prefix_reg
  import rdec_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   take,
  input  logic   clr,
  input  bkind_e kind,
  input  byte_t  b,
  output pfx_t   pfx
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pfx <= '0;
    end else if (take) begin
      case (kind)
        BK_OPSZ: begin
          pfx.opsz  <= 1'b1;
          pfx.rex_v <= 1'b0;
          pfx.w     <= 1'b0;
          pfx.r     <= 1'b0;
          pfx.x     <= 1'b0;
          pfx.b     <= 1'b0;
        end
        BK_ADSZ: begin
          pfx.adsz  <= 1'b1;
          pfx.rex_v <= 1'b0;
          pfx.w     <= 1'b0;
          pfx.r     <= 1'b0;
          pfx.x     <= 1'b0;
          pfx.b     <= 1'b0;
        end
        BK_REX: begin
          pfx.rex_v <= 1'b1;
          {pfx.w, pfx.r, pfx.x, pfx.b} <= b[REXB_W-1:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rdec_operand_build.sv
module rdec_operand_build
  import rdec_pkg::*;
(
  input  op_e     op,
  input  byte_t   b,
  input  pfx_t    pfx,
  output result_t res
);
  logic [1:0]         mod_f;
  logic [FIELD_W-1:0] reg_f;
  logic [FIELD_W-1:0] rm_f;
  osz_e               data_sz;

  assign mod_f = b[7:6];
  assign reg_f = b[5:3];
  assign rm_f  = b[FIELD_W-1:0];

  always_comb begin
    if (pfx.w)         data_sz = OSZ_64;
    else if (pfx.opsz) data_sz = OSZ_16;
    else               data_sz = OSZ_32;
  end

  always_comb begin
    res          = '0;
    res.op       = op;
    res.osz      = data_sz;
    res.addr64   = ~pfx.adsz;
    res.rex_seen = pfx.rex_v;
    case (op)
      OP_MOV: begin
        res.src     = {pfx.r, reg_f};
        res.dst     = {pfx.b, rm_f};
        res.illegal = (mod_f != 2'b11);
      end
      OP_LEA: begin
        res.dst     = {pfx.r, reg_f};
        res.src     = {pfx.b, rm_f};
        res.src_mem = 1'b1;
        res.illegal = (mod_f != 2'b00) || (rm_f == 3'd4) || (rm_f == 3'd5);
      end
      OP_PUSH: begin
        res.osz = OSZ_64;
        res.src = {pfx.b, rm_f};
      end
      default: res.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/insn_reg_decoder.sv
module insn_reg_decoder
  import rdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic             in_ready,
  output logic             dec_valid,
  output logic [1:0]       dec_op,
  output logic [1:0]       dec_osize,
  output logic             dec_addr64,
  output logic [REG_W-1:0] dec_dst,
  output logic [REG_W-1:0] dec_src,
  output logic             dec_src_mem,
  output logic             dec_illegal,
  output logic             dec_rex
);
  typedef enum logic {PH_PREFIX, PH_MODRM} phase_e;

  phase_e  phase_q;
  op_e     op_q;
  logic    ready_q;
  logic    valid_q;
  result_t res_q;
  bkind_e  kind;
  pfx_t    pfx;
  result_t res;
  op_e     build_op;
  logic    acc;
  logic    in_pfx;
  logic    is_prefix;
  logic    start_modrm;
  logic    emit;

  assign acc         = in_valid && ready_q;
  assign in_pfx      = (phase_q == PH_PREFIX);
  assign is_prefix   = (kind == BK_OPSZ) || (kind == BK_ADSZ) || (kind == BK_REX);
  assign start_modrm = acc && in_pfx && ((kind == BK_MOV) || (kind == BK_LEA));
  assign emit        = acc && (!in_pfx || (kind == BK_PUSH) || (kind == BK_OTHER));

  always_comb begin
    if (!in_pfx)              build_op = op_q;
    else if (kind == BK_PUSH) build_op = OP_PUSH;
    else                      build_op = OP_NONE;
  end

  rdec_byte_class u_class (
    .b    (in_byte),
    .kind (kind)
  );

  rdec_prefix_reg u_pfx (
    .clk  (clk),
    .rst  (rst),
    .take (acc && in_pfx && is_prefix),
    .clr  (emit),
    .kind (kind),
    .b    (in_byte),
    .pfx  (pfx)
  );

  rdec_operand_build u_build (
    .op  (build_op),
    .b   (in_byte),
    .pfx (pfx),
    .res (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      phase_q <= PH_PREFIX;
      op_q    <= OP_NONE;
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      valid_q <= emit;
      if (emit) res_q <= res;
      if (start_modrm) begin
        phase_q <= PH_MODRM;
        op_q    <= (kind == BK_MOV) ? OP_MOV : OP_LEA;
      end else if (acc && !in_pfx) begin
        phase_q <= PH_PREFIX;
      end
    end
  end

  assign in_ready    = ready_q;
  assign dec_valid   = valid_q;
  assign dec_op      = res_q.op;
  assign dec_osize   = res_q.osz;
  assign dec_addr64  = res_q.addr64;
  assign dec_dst     = res_q.dst;
  assign dec_src     = res_q.src;
  assign dec_src_mem = res_q.src_mem;
  assign dec_illegal = res_q.illegal;
  assign dec_rex     = res_q.rex_seen;
endmodule

// File: rtl/rdec_checker.sv
module rdec_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       dec_valid,
  input logic [1:0] dec_op,
  input logic [1:0] dec_osize,
  input logic       dec_src_mem,
  input logic       dec_illegal
);
  a_r1_ready_out_of_reset: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> in_ready);

  a_r2_strobe_after_byte: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(in_valid && in_ready));

  a_r6_push_shape: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_op == 2'd3) |-> (dec_osize == 2'd2 && !dec_src_mem && !dec_illegal));

  a_r5_lea_memory: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_op == 2'd2 && !dec_illegal) |-> dec_src_mem);

  a_r3_mov_register: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_op == 2'd1) |-> !dec_src_mem);

  a_r10_unknown_illegal: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_op == 2'd0) |-> dec_illegal);

  a_r4_size_code: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_osize != 2'd3));
endmodule

bind insn_reg_decoder rdec_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .dec_valid   (dec_valid),
  .dec_op      (dec_op),
  .dec_osize   (dec_osize),
  .dec_src_mem (dec_src_mem),
  .dec_illegal (dec_illegal)
);

// File: tb/tb_insn_reg_decoder.sv
`timescale 1ns/1ps
module tb_insn_reg_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, dec_valid, dec_addr64, dec_src_mem, dec_illegal, dec_rex;
  logic [1:0] dec_op, dec_osize;
  logic [3:0] dec_dst, dec_src;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  insn_reg_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .dec_valid(dec_valid), .dec_op(dec_op), .dec_osize(dec_osize), .dec_addr64(dec_addr64),
    .dec_dst(dec_dst), .dec_src(dec_src), .dec_src_mem(dec_src_mem),
    .dec_illegal(dec_illegal), .dec_rex(dec_rex)
  );

  typedef struct packed {
    logic [31:0] bytes;
    logic [2:0]  len;
    logic [3:0]  req;
    logic [1:0]  op;
    logic [1:0]  osz;
    logic        a64;
    logic [3:0]  dst;
    logic [3:0]  src;
    logic        mem;
    logic        ill;
    logic        rex;
  } vec_t;

  localparam int NV = 27;
  // bytes, len, req, op, osz, a64, dst, src, mem, ill, rex
  localparam vec_t TBL [0:NV-1] = '{
    '{32'h89C80000, 3'd2, 4'd3,  2'd1, 2'd1, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0}, // R3
    '{32'h4189C800, 3'd3, 4'd3,  2'd1, 2'd1, 1'b1, 4'd8, 4'd1, 1'b0, 1'b0, 1'b1}, // R3
    '{32'h4489C800, 3'd3, 4'd3,  2'd1, 2'd1, 1'b1, 4'd0, 4'd9, 1'b0, 1'b0, 1'b1}, // R3
    '{32'h4D89C800, 3'd3, 4'd4,  2'd1, 2'd2, 1'b1, 4'd8, 4'd9, 1'b0, 1'b0, 1'b1}, // R4
    '{32'h4889C800, 3'd3, 4'd4,  2'd1, 2'd2, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1}, // R4
    '{32'h6689C800, 3'd3, 4'd4,  2'd1, 2'd0, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0}, // R4
    '{32'h664889C8, 3'd4, 4'd4,  2'd1, 2'd2, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1}, // R4 W wins
    '{32'h89C80000, 3'd2, 4'd11, 2'd1, 2'd1, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0}, // R11
    '{32'h678D0100, 3'd3, 4'd5,  2'd2, 2'd1, 1'b0, 4'd0, 4'd1, 1'b1, 1'b0, 1'b0}, // R5
    '{32'h67458D01, 3'd4, 4'd5,  2'd2, 2'd1, 1'b0, 4'd8, 4'd9, 1'b1, 1'b0, 1'b1}, // R5
    '{32'h4C8D0100, 3'd3, 4'd5,  2'd2, 2'd2, 1'b1, 4'd8, 4'd1, 1'b1, 1'b0, 1'b1}, // R5
    '{32'h498D0100, 3'd3, 4'd5,  2'd2, 2'd2, 1'b1, 4'd0, 4'd9, 1'b1, 1'b0, 1'b1}, // R5
    '{32'h50000000, 3'd1, 4'd6,  2'd3, 2'd2, 1'b1, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0}, // R6
    '{32'h41500000, 3'd2, 4'd6,  2'd3, 2'd2, 1'b1, 4'd0, 4'd8, 1'b0, 1'b0, 1'b1}, // R6
    '{32'h66570000, 3'd2, 4'd6,  2'd3, 2'd2, 1'b1, 4'd0, 4'd7, 1'b0, 1'b0, 1'b0}, // R6
    '{32'h416689C8, 3'd4, 4'd7,  2'd1, 2'd0, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0}, // R7
    '{32'h48678D01, 3'd4, 4'd7,  2'd2, 2'd1, 1'b0, 4'd0, 4'd1, 1'b1, 1'b0, 1'b0}, // R7
    '{32'h444189C8, 3'd4, 4'd8,  2'd1, 2'd1, 1'b1, 4'd8, 4'd1, 1'b0, 1'b0, 1'b1}, // R8
    '{32'h40570000, 3'd2, 4'd9,  2'd3, 2'd2, 1'b1, 4'd0, 4'd7, 1'b0, 1'b0, 1'b1}, // R9
    '{32'h8D410000, 3'd2, 4'd10, 2'd2, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h8D040000, 3'd2, 4'd10, 2'd2, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h8D050000, 3'd2, 4'd10, 2'd2, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h8DC10000, 3'd2, 4'd10, 2'd2, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h89010000, 3'd2, 4'd10, 2'd1, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h90000000, 3'd1, 4'd10, 2'd0, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h66679000, 3'd3, 4'd10, 2'd0, 2'd0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0}, // R10
    '{32'h8D010000, 3'd2, 4'd11, 2'd2, 2'd1, 1'b1, 4'd0, 4'd1, 1'b1, 1'b0, 1'b0}  // R11
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one byte, return just after the accepting edge
  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #1;
    @(negedge clk);
    in_valid = 1'b0;
    #0;
  endtask

  task automatic put_sample(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] full_res();
    return {13'd0, dec_op, dec_osize, dec_addr64, dec_dst, dec_src, dec_src_mem, dec_illegal, dec_rex};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ready in reset", {31'd0, in_ready}, 32'd0);
    chk("R1", "valid in reset", {31'd0, dec_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1", "ready after reset", {31'd0, in_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(TBL[v].len); i++) begin
        put_sample(TBL[v].bytes[31-8*i -: 8]);
        if (i < int'(TBL[v].len) - 1)
          chk("R2", "no strobe mid-instruction", {31'd0, dec_valid}, 32'd0);
      end
      checks++;
      if (dec_valid !== 1'b1) begin
        fails++;
        $display("FAIL R%0d vector %0d strobe: actual %0b expected 1", TBL[v].req, v, dec_valid);
      end
      checks++;
      if (TBL[v].ill) begin
        if ({dec_op, dec_illegal} !== {TBL[v].op, 1'b1}) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual %0h expected %0h", TBL[v].req, v,
                   {dec_op, dec_illegal}, {TBL[v].op, 1'b1});
        end
      end else begin
        if (full_res() !== {13'd0, TBL[v].op, TBL[v].osz, TBL[v].a64, TBL[v].dst,
                            TBL[v].src, TBL[v].mem, TBL[v].ill, TBL[v].rex}) begin
          fails++;
          $display("FAIL R%0d vector %0d: actual %0h expected %0h", TBL[v].req, v, full_res(),
                   {13'd0, TBL[v].op, TBL[v].osz, TBL[v].a64, TBL[v].dst,
                    TBL[v].src, TBL[v].mem, TBL[v].ill, TBL[v].rex});
        end
      end
      @(negedge clk);
      in_valid = 1'b0;
    end

    // R2: gaps between bytes, strobe lasts one cycle
    put(8'h48);
    repeat (3) begin
      @(posedge clk); #1;
      chk("R2", "idle no strobe", {31'd0, dec_valid}, 32'd0);
    end
    put(8'h89);
    chk("R2", "opcode no strobe", {31'd0, dec_valid}, 32'd0);
    @(posedge clk); #1;
    put_sample(8'hC8);
    chk("R2", "gapped move", full_res(), {13'd0, 2'd1, 2'd2, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b1});
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2", "strobe one cycle", {31'd0, dec_valid}, 32'd0);

    // R11: reset in the middle of an instruction
    put(8'h66);
    put(8'h4D);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1", "valid in mid reset", {31'd0, dec_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    put(8'h89);
    put_sample(8'hC8);
    chk("R11", "prefixes cleared by reset", full_res(),
        {13'd0, 2'd1, 2'd1, 1'b1, 4'd0, 4'd1, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    in_valid = 1'b0;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule